// File: doc/BRIEF.md
# Wavefront Integer Add/Subtract Unit with Lane Carry Mask

This unit performs one 32-bit integer add or subtract in every lane of a 64-lane wavefront at once. Each lane takes one word from each of two source vectors. The carry or borrow that each lane produces is gathered into a single 64-bit scalar mask, with bit n belonging to lane n. The chained variants read a mask of the same shape to take in one carry or borrow bit per lane. A surrounding pipeline uses this to build wide integer arithmetic: it passes the mask from one operation into the carry input of the next.

An operation starts with a one-cycle strobe that comes with an opcode, the two operand vectors, the carry-in mask and an execute mask. On the next clock edge the unit registers the lane results and the output mask, and it raises a done pulse for one cycle. A lane whose execute bit is clear keeps the result it held before, and its output mask bit is 0. Operand fetch and register-file writeback are handled outside this unit.

Top module: `wave_addsub`

## Requirements
- R1: After synchronous reset every lane result is 0, the carry/borrow mask is 0 and done is 0.
- R2: Opcode 0x25 (add) writes a+b (mod 2^32) into each enabled lane and sets mask bit n to the carry-out of lane n. The carry-in mask has no effect.
- R3: Opcode 0x26 (subtract) writes a-b and opcode 0x27 (reverse subtract) writes b-a. Mask bit n is set when the subtrahend of lane n is larger than its minuend as unsigned numbers. The carry-in mask has no effect.
- R4: Opcode 0x28 (add with carry) writes a+b+cin[n] into lane n and sets mask bit n to that lane's carry-out.
- R5: Opcode 0x29 writes a-b-cin[n] and opcode 0x2A writes b-a-cin[n]. Mask bit n is set when the subtrahend plus the borrow-in is larger than the minuend.
- R6: A lane whose execute-mask bit is 0 keeps its previous result, and its bit in the output mask is 0.
- R7: Results and mask change on the first rising edge that samples start high. Done is high for exactly the cycle that follows each start cycle.
- R8: While start is low, results and mask hold their values whatever the other inputs do.
- R9: Any opcode outside 0x25..0x2A leaves every lane result unchanged and clears the whole output mask. Done still pulses.
- R10: Lane n occupies bits [32n+31:32n] of the packed source and result vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation in this cycle |
| opcode | input | 6 | Operation select |
| src_a | input | 2048 | First operand vector, packed by lane |
| src_b | input | 2048 | Second operand vector, packed by lane |
| carry_in | input | 64 | Carry/borrow-in mask, one bit per lane |
| exec_mask | input | 64 | Lane enable mask |
| result | output | 2048 | Registered lane results, packed by lane |
| carry_out | output | 64 | Registered carry/borrow-out mask |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench targets the carry and borrow boundaries.

- **All-ones plus one.** A design with the carry bit taken from the wrong position would report no carry here.
- **Zero minus one.** A design that computes the borrow as a carry (inverted) would flag the wrong lanes.
- **Equal operands with a borrow-in.** This must borrow and wrap to all ones; a design that compares only the operands would miss the borrow.
- **Reversed operand order, masked lanes and out-of-range opcodes.** These expose a swapped subtraction, stale or leaked carry bits in disabled lanes, and lanes written when they should not be.
- **Randomized operations.** Random operations with biased extreme operands, checked against a bench model, catch lane-indexing and mask-packing errors.

// File: rtl/wave_addsub_pkg.sv
package wave_addsub_pkg;

    localparam int DEF_LANES  = 64;
    localparam int DEF_LANE_W = 32;

    typedef enum logic [5:0] {
        OPC_ADD     = 6'h25,
        OPC_SUB     = 6'h26,
        OPC_SUBREV  = 6'h27,
        OPC_ADDC    = 6'h28,
        OPC_SUBB    = 6'h29,
        OPC_SUBBREV = 6'h2A
    } opcode_e;

    // Control word carried from the decoder to every lane
    typedef struct packed {
        logic valid;     // opcode recognised
        logic subtract;  // difference instead of sum
        logic swap;      // operands exchanged (reverse forms)
        logic chain;     // per-lane carry/borrow-in used
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [5:0] code);
        op_ctrl_t c;
        c = '0;
        case (code)
            OPC_ADD:     c = '{valid: 1'b1, subtract: 1'b0, swap: 1'b0, chain: 1'b0};
            OPC_SUB:     c = '{valid: 1'b1, subtract: 1'b1, swap: 1'b0, chain: 1'b0};
            OPC_SUBREV:  c = '{valid: 1'b1, subtract: 1'b1, swap: 1'b1, chain: 1'b0};
            OPC_ADDC:    c = '{valid: 1'b1, subtract: 1'b0, swap: 1'b0, chain: 1'b1};
            OPC_SUBB:    c = '{valid: 1'b1, subtract: 1'b1, swap: 1'b0, chain: 1'b1};
            OPC_SUBBREV: c = '{valid: 1'b1, subtract: 1'b1, swap: 1'b1, chain: 1'b1};
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wave_addsub_decode.sv
module wave_addsub_decode
    import wave_addsub_pkg::*;
(
    input  logic [5:0] opcode,
    output op_ctrl_t   ctrl
);
    always_comb ctrl = decode_op(opcode);

    // R9: only the six defined codes are accepted
    always_comb begin
        a_r9_valid_range: assert (ctrl.valid == (opcode >= 6'h25 && opcode <= 6'h2A));
    end
endmodule

// File: rtl/wave_addsub_lane.sv
module wave_addsub_lane
    import wave_addsub_pkg::*;
#(
    parameter int LANE_W = DEF_LANE_W
) (
    input  op_ctrl_t          ctrl,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic              cin,
    output logic [LANE_W-1:0] value,
    output logic              flag
);
    logic [LANE_W-1:0] lhs, rhs;
    logic              ci;
    logic [LANE_W:0]   wide;

    always_comb begin
        lhs  = ctrl.swap ? b : a;
        rhs  = ctrl.swap ? a : b;
        ci   = ctrl.chain & cin;
        // Subtract borrow shows as bit LANE_W of the extended difference
        if (ctrl.subtract)
            wide = {1'b0, lhs} - {1'b0, rhs} - {{LANE_W{1'b0}}, ci};
        else
            wide = {1'b0, lhs} + {1'b0, rhs} + {{LANE_W{1'b0}}, ci};
        value = wide[LANE_W-1:0];
        flag  = wide[LANE_W];
    end

    // R3/R5: borrow asserted exactly when subtrahend plus borrow-in exceeds minuend
    always_comb begin
        if (ctrl.subtract)
            a_r5_borrow_rule: assert (flag == (({1'b0, rhs} + {{LANE_W{1'b0}}, ci}) > {1'b0, lhs}));
    end
endmodule

// File: rtl/wave_addsub.sv
module wave_addsub
    import wave_addsub_pkg::*;
#(
    parameter int NLANES = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [5:0]               opcode,
    input  logic [NLANES*LANE_W-1:0] src_a,
    input  logic [NLANES*LANE_W-1:0] src_b,
    input  logic [NLANES-1:0]        carry_in,
    input  logic [NLANES-1:0]        exec_mask,
    output logic [NLANES*LANE_W-1:0] result,
    output logic [NLANES-1:0]        carry_out,
    output logic                     done
);
    localparam int VEC_W = NLANES * LANE_W;

    op_ctrl_t ctrl;
    logic     done_q;

    wave_addsub_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    // R10: lane n sits at bits [n*LANE_W +: LANE_W]
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_val;
        logic              lane_flag;
        logic [LANE_W-1:0] res_q;
        logic              flag_q;
        logic              write_en;

        wave_addsub_lane #(.LANE_W(LANE_W)) u_lane (
            .ctrl  (ctrl),
            .a     (src_a[g*LANE_W +: LANE_W]),
            .b     (src_b[g*LANE_W +: LANE_W]),
            .cin   (carry_in[g]),
            .value (lane_val),
            .flag  (lane_flag)
        );

        assign write_en = start & exec_mask[g] & ctrl.valid;

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q  <= '0;
                flag_q <= 1'b0;
            end else if (start) begin
                flag_q <= write_en & lane_flag;
                if (write_en)
                    res_q <= lane_val;
            end
        end

        assign result[g*LANE_W +: LANE_W] = res_q;
        assign carry_out[g]               = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= start;
    end
    assign done = done_q;

    // R7: done pulse follows each start by one cycle
    a_r7_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    // R6: disabled lanes never report carry/borrow
    a_r6_masked_carry_zero: assert property (@(posedge clk) disable iff (rst)
        start |=> ((carry_out & ~$past(exec_mask)) == '0));
    // R8: state holds without start
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(carry_out)));
    // R9: unrecognised opcode touches no lane and clears the mask
    a_r9_bad_opcode: assert property (@(posedge clk) disable iff (rst)
        (start && !ctrl.valid) |=> (carry_out == '0 && $stable(result)));

    logic [VEC_W-1:0] unused_chk;
    assign unused_chk = result;
endmodule

// File: tb/wave_addsub_tb_top.sv
module wave_addsub_tb_top;
    localparam int N = 64;
    localparam int W = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic [5:0]       opcode;
    logic [N*W-1:0]   src_a, src_b;
    logic [N-1:0]     carry_in, exec_mask;
    logic [N*W-1:0]   result;
    logic [N-1:0]     carry_out;
    logic             done;

    int errors = 0;
    int checks = 0;

    logic [N*W-1:0] exp_res;
    logic [N-1:0]   exp_cm;

    always #2 clk = ~clk;

    wave_addsub dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .carry_in(carry_in), .exec_mask(exec_mask),
        .result(result), .carry_out(carry_out), .done(done)
    );

    // Bench model of one lane: {flag, value}; bit 33 = opcode recognised
    function automatic logic [33:0] model_lane(input logic [5:0] code,
            input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
        logic [W:0] r;
        logic [W:0] need;
        case (code)
            6'h25: r = a + b;
            6'h28: r = a + b + ci;
            6'h26: begin r[W-1:0] = a - b;      need = b;      r[W] = need > a; end
            6'h27: begin r[W-1:0] = b - a;      need = a;      r[W] = need > b; end
            6'h29: begin r[W-1:0] = a - b - ci; need = b + ci; r[W] = need > a; end
            6'h2A: begin r[W-1:0] = b - a - ci; need = a + ci; r[W] = need > b; end
            default: return {1'b0, 33'h0};
        endcase
        if (code == 6'h25 || code == 6'h28)
            r = {1'b0, a} + {1'b0, b} + ((code == 6'h28) ? {{W{1'b0}}, ci} : '0);
        return {1'b1, r};
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        checks++;
        if (result !== exp_res) begin
            errors++;
            $display("FAIL %s result: actual=%h expected=%h", tag, result, exp_res);
        end
        checks++;
        if (carry_out !== exp_cm) begin
            errors++;
            $display("FAIL %s mask: actual=%h expected=%h", tag, carry_out, exp_cm);
        end
    endtask

    // Issue one operation with the current operands; check R7 latency and R8 hold
    task automatic run_op(input logic [5:0] code, input string tag);
        logic [33:0] m;
        @(negedge clk);
        opcode = code;
        start  = 1'b1;
        for (int n = 0; n < N; n++) begin
            m = model_lane(code, src_a[n*W +: W], src_b[n*W +: W], carry_in[n]);
            if (exec_mask[n] && m[33]) exp_res[n*W +: W] = m[W-1:0];
            exp_cm[n] = exec_mask[n] & m[33] & m[W];
        end
        @(negedge clk);
        start = 1'b0;
        check_bit(done, 1'b1, {tag, " R7 done"});
        check_state(tag);
        src_a  = {N{$urandom}};
        opcode = 6'h25;
        exec_mask = '1;
        @(negedge clk);
        check_bit(done, 1'b0, {tag, " R7 done single"});
        check_state({tag, " R8 hold"});
    endtask

    function automatic logic [W-1:0] rnd_word();
        case ($urandom % 4)
            0: return '0;
            1: return '1;
            2: return 32'h8000_0000 + ($urandom % 4);
            default: return $urandom;
        endcase
    endfunction

    task automatic fill_random();
        for (int n = 0; n < N; n++) begin
            src_a[n*W +: W] = rnd_word();
            src_b[n*W +: W] = ($urandom % 5 == 0) ? src_a[n*W +: W] : rnd_word();
        end
        carry_in  = {$urandom, $urandom};
        exec_mask = ($urandom % 3 == 0) ? '1 : {$urandom, $urandom};
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] ops [6];
        ops = '{6'h25, 6'h26, 6'h27, 6'h28, 6'h29, 6'h2A};
        void'($urandom(32'hC0FFEE));
        rst = 1'b1; start = 1'b0; opcode = '0;
        src_a = '1; src_b = '1; carry_in = '1; exec_mask = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_res = '0; exp_cm = '0;
        // R1 reset state
        check_state("R1 reset");
        check_bit(done, 1'b0, "R1 reset done");

        // R2/R10: all-ones plus 1 in even lanes -> carry pattern 0x5555...
        for (int n = 0; n < N; n++) begin
            src_a[n*W +: W] = '1;
            src_b[n*W +: W] = (n % 2 == 0) ? 32'd1 : 32'd0;
        end
        carry_in = '1; exec_mask = '1;
        run_op(6'h25, "R2 add carry");
        check_bit(exp_cm == {32{2'b01}}, 1'b1, "R2 model pattern");

        // R3: 0 - 1 borrows in every lane; reverse form does not
        src_a = '0;
        for (int n = 0; n < N; n++) src_b[n*W +: W] = 32'd1;
        carry_in = '0; exec_mask = '1;
        run_op(6'h26, "R3 sub borrow");
        src_a = '0;
        for (int n = 0; n < N; n++) src_b[n*W +: W] = 32'd1;
        run_op(6'h27, "R3 subrev");

        // R4: max + 0 + carry-in wraps with carry
        src_a = '1; src_b = '0; carry_in = {32{2'b10}}; exec_mask = '1;
        run_op(6'h28, "R4 addc chain");

        // R5: equal operands with borrow-in -> all ones and borrow
        for (int n = 0; n < N; n++) begin
            src_a[n*W +: W] = 32'h1234_5678 + n;
            src_b[n*W +: W] = 32'h1234_5678 + n;
        end
        carry_in = {32{2'b01}}; exec_mask = '1;
        run_op(6'h29, "R5 subb equal");
        for (int n = 0; n < N; n++) begin
            src_a[n*W +: W] = 32'd7;
            src_b[n*W +: W] = 32'd7;
        end
        carry_in = '1;
        run_op(6'h2A, "R5 subbrev equal");

        // R6: half the lanes disabled
        src_a = '1; src_b = '1; carry_in = '0;
        exec_mask = {32'h0, 32'hFFFF_FFFF};
        run_op(6'h25, "R6 masked lanes");

        // R9: codes just outside the defined range
        src_a = '1; src_b = '1; exec_mask = '1;
        run_op(6'h24, "R9 bad opcode low");
        run_op(6'h2B, "R9 bad opcode high");

        // Random mix across all operations (R2..R6)
        for (int i = 0; i < 300; i++) begin
            fill_random();
            run_op(ops[$urandom % 6], "R2-5 random op");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule